// File: doc/BRIEF.md
# Variable-Length Synchronous Serial Port

This block is a shift-register serial interface with three lines: a bidirectional shift clock, serial data in and serial data out. Software writes a configuration word and a transmit byte, then starts a transfer of either eight bits or four bits. Data leaves most significant bit first. Each outgoing bit changes on a falling clock edge, and each incoming bit is captured on the rising edge that follows.

The shift clock can come from inside the block, where a divider generates it from the system clock. It can also come from an external master that drives the same pin. In that case the pin's output enable is released, and the incoming clock passes through a two-flop synchroniser and an edge detector. When the last rising edge arrives, the block raises a sticky done flag and a one-cycle interrupt pulse. In internal mode the clock then stops high. The data output driver can be switched off by software, which frees that pin for other use.

Top module: `sio_port`

## Requirements
- R1: After reset, busy, done and irq are 0, rxData is 0, sckOut and sdOut are 1, sckOe is 1 and sdOe is 1. The reset configuration is 8-bit, internal clock, output enabled.
- R2: In 8-bit mode (cfgLen8=1), the transmit byte leaves MSB first, one bit per falling edge. After the eighth rising edge, rxData holds the eight received bits with the first received bit in bit 7.
- R3: In 4-bit mode (cfgLen8=0), only rxData[3:0] shifts. txData[3] goes out first, and the first received bit ends in bit 3. rxData[7:4] keeps the transmit value.
- R4: sdOut changes only after a falling edge of the shift clock. sdIn is sampled only on a rising edge.
- R5: With the internal clock, sckOut stays high while idle and toggles every HALF_CYC system cycles while busy. It is high again once the transfer ends.
- R6: At the end of a transfer, done is set and irq is high for exactly one cycle, while busy falls. An accepted start clears done.
- R7: busy is 1 throughout a transfer. Data and configuration writes made while busy have no effect, and neither does a start.
- R8: With cfgExtClk=1, sckOe is 0 and the transfer advances on the synchronised edges of sckIn.
- R9: With cfgOutOff=1, sdOe is 0. The shift register still runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgLen8 | input | 1 | 1: 8-bit transfer, 0: 4-bit transfer |
| cfgExtClk | input | 1 | 1: shift clock taken from the pin |
| cfgOutOff | input | 1 | 1: serial data output disabled |
| dataWr | input | 1 | Transmit data write strobe |
| txData | input | DATA_W | Transmit data |
| start | input | 1 | Start a transfer |
| rxData | output | DATA_W | Shift register contents / received data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion pulse |
| sckIn | input | 1 | Shift clock from pin |
| sckOut | output | 1 | Shift clock to pin |
| sckOe | output | 1 | Shift clock output enable |
| sdIn | input | 1 | Serial data in |
| sdOut | output | 1 | Serial data out |
| sdOe | output | 1 | Serial data output enable |

## Verification
The assertions assume that writes and starts arrive as single-cycle strobes that are synchronous to clk. They also assume that an external shift clock stays in each level far longer than three system cycles, so that every edge is seen once. The stimulus meets both assumptions. It drives the external clock with 8-cycle phases. In internal mode it changes sdIn only at the negative system-clock edge after a falling shift-clock edge, so the data is stable across the next rising edge.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef struct packed {
    logic load;   // copy txData into the shift register
    logic fall;   // shift clock falling edge: present next bit
    logic rise;   // shift clock rising edge: capture input bit
    logic nib;    // short (nibble) transfer selected
  } sioStb_t;

  typedef struct packed {
    logic len8;
    logic ext;
    logic soOff;
  } sioCfg_t;

endpackage

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SHORT_W  = 4,
  parameter int HALF_CYC = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    cfgWr,
  input  logic    cfgLen8,
  input  logic    cfgExtClk,
  input  logic    cfgOutOff,
  input  logic    dataWr,
  input  logic    sckIn,
  output sioStb_t stb,
  output sioCfg_t cfg,
  output logic    busy,
  output logic    done,
  output logic    irq,
  output logic    sckOut,
  output logic    sckOe
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam int DIV_W = $clog2(HALF_CYC) + 1;

  logic [2:0]       sckSync;
  logic [CNT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divCnt;
  logic             sckReg;
  logic             extFall, extRise, tick, intFall, intRise;
  logic             fallEv, riseEv, lastBit, accept, finish;

  // two synchroniser stages plus one history stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckSync <= 3'b111;
    else       sckSync <= {sckSync[1:0], sckIn};
  end

  always_comb begin
    extFall = sckSync[2] & ~sckSync[1];
    extRise = ~sckSync[2] & sckSync[1];
    tick    = busy && !cfg.ext && (divCnt == DIV_W'(HALF_CYC - 1));
    intFall = tick && sckReg;
    intRise = tick && !sckReg;
    fallEv  = cfg.ext ? (busy && extFall) : intFall;
    riseEv  = cfg.ext ? (busy && extRise) : intRise;
    lastBit = cfg.len8 ? (bitCnt == CNT_W'(DATA_W - 1))
                       : (bitCnt == CNT_W'(SHORT_W - 1));
    accept  = start && !busy;
    finish  = riseEv && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= '{len8: 1'b1, ext: 1'b0, soOff: 1'b0};
      busy   <= 1'b0;
      done   <= 1'b0;
      irq    <= 1'b0;
      bitCnt <= '0;
      divCnt <= '0;
      sckReg <= 1'b1;
    end else begin
      irq <= finish;
      if (cfgWr && !busy) begin
        cfg.len8  <= cfgLen8;
        cfg.ext   <= cfgExtClk;
        cfg.soOff <= cfgOutOff;
      end
      if (accept) begin
        busy   <= 1'b1;
        done   <= 1'b0;
        bitCnt <= '0;
        divCnt <= '0;
      end else begin
        if (finish) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        if (riseEv) bitCnt <= bitCnt + 1'b1;
        if (busy && !cfg.ext) divCnt <= tick ? '0 : divCnt + 1'b1;
      end
      if (intFall)      sckReg <= 1'b0;
      else if (intRise) sckReg <= 1'b1;
    end
  end

  always_comb begin
    stb.load = dataWr && !busy;
    stb.fall = fallEv;
    stb.rise = riseEv;
    stb.nib  = !cfg.len8;
    sckOut   = sckReg;
    sckOe    = !cfg.ext;
  end

  // checker: cycles since last clock toggle or accepted start
  logic [DIV_W-1:0] holdCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdCnt <= '0;
    else if (accept || intFall || intRise) holdCnt <= '0;
    else if (holdCnt != '1) holdCnt <= holdCnt + 1'b1;
  end

  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    $changed(sckReg) |-> $past(holdCnt) == DIV_W'(HALF_CYC - 1)); // R5
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sckReg); // R5
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq); // R6
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(cfg)); // R7

endmodule

// File: rtl/sio_dpath.sv
module sio_dpath
  import sio_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SHORT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  sioStb_t           stb,
  input  logic [DATA_W-1:0] txData,
  input  logic              sdIn,
  output logic [DATA_W-1:0] rxData,
  output logic              sdOut
);
  logic [DATA_W-1:0] shReg;
  logic              outBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      outBit <= 1'b1;
    end else begin
      if (stb.load) begin
        shReg <= txData;
      end else if (stb.rise) begin
        if (stb.nib) shReg[SHORT_W-1:0] <= {shReg[SHORT_W-2:0], sdIn};
        else         shReg              <= {shReg[DATA_W-2:0], sdIn};
      end
      if (stb.fall)
        outBit <= stb.nib ? shReg[SHORT_W-1] : shReg[DATA_W-1];
    end
  end

  assign rxData = shReg;
  assign sdOut  = outBit;

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    stb.rise && stb.nib && !stb.load |=> $stable(shReg[DATA_W-1:SHORT_W])); // R3
  AST_RX_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rise && !stb.load |=> $stable(shReg)); // R4

endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SHORT_W  = 4,
  parameter int HALF_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic              cfgLen8,
  input  logic              cfgExtClk,
  input  logic              cfgOutOff,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] txData,
  input  logic              start,
  output logic [DATA_W-1:0] rxData,
  output logic              busy,
  output logic              done,
  output logic              irq,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              sdOe
);
  sioStb_t stb;
  sioCfg_t cfg;

  sio_ctrl #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .HALF_CYC(HALF_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgWr(cfgWr), .cfgLen8(cfgLen8),
    .cfgExtClk(cfgExtClk), .cfgOutOff(cfgOutOff), .dataWr(dataWr),
    .sckIn(sckIn), .stb(stb), .cfg(cfg), .busy(busy), .done(done),
    .irq(irq), .sckOut(sckOut), .sckOe(sckOe));

  sio_dpath #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .txData(txData), .sdIn(sdIn),
    .rxData(rxData), .sdOut(sdOut));

  assign sdOe = !cfg.soOff;

  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    sckOe && $changed(sdOut) |-> $fell(sckOut)); // R4
  AST_IRQ_DONE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> done && !busy); // R6

endmodule

// File: tb/sim_sio_port.sv
module sim_sio_port;
  localparam int HALF = 4;

  logic clk = 0, rstN = 0;
  logic cfgWr = 0, cfgLen8 = 1, cfgExtClk = 0, cfgOutOff = 0;
  logic dataWr = 0, start = 0, sckIn = 1, sdIn = 0;
  logic [7:0] txData = 0;
  logic [7:0] rxData;
  logic busy, done, irq, sckOut, sckOe, sdOut, sdOe;

  int checks = 0, errors = 0;

  sio_port #(.DATA_W(8), .SHORT_W(4), .HALF_CYC(HALF)) u0 (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgLen8(cfgLen8),
    .cfgExtClk(cfgExtClk), .cfgOutOff(cfgOutOff), .dataWr(dataWr),
    .txData(txData), .start(start), .rxData(rxData), .busy(busy),
    .done(done), .irq(irq), .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe),
    .sdIn(sdIn), .sdOut(sdOut), .sdOe(sdOe));

  always #10 clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard queues
  logic [7:0] expRx[$];
  logic [7:0] expTx[$];
  logic       expLen8[$];

  // slave model and monitor state
  logic [7:0] slvRx;
  int         slvIdx;
  logic [7:0] obs;
  logic       prevSck = 1;
  int         toggleGap;
  logic       gapOk;
  logic       sawToggle;
  logic       irqPrev = 0;

  always @(negedge clk) begin
    if (rstN) begin
      toggleGap++;
      if (sckOut != prevSck) begin
        if (sawToggle && toggleGap != HALF) gapOk = 1'b0;
        sawToggle = 1'b1;
        toggleGap = 0;
        if (!sckOut) begin
          sdIn = slvRx[slvIdx];
          slvIdx--;
        end else begin
          obs = {obs[6:0], sdOut};
        end
      end
      prevSck = sckOut;
      if (irqPrev) begin
        check(!irq, "R6 irq single cycle", {7'd0, irq}, 8'h00);
        check(sckOut, "R5 clock stopped high", {7'd0, sckOut}, 8'h01);
      end
      if (irq && expRx.size() > 0) begin
        logic [7:0] eRx, eTx;
        logic       eL8;
        eRx = expRx.pop_front();
        eTx = expTx.pop_front();
        eL8 = expLen8.pop_front();
        if (eL8) begin
          check(rxData == eRx, "R2 8-bit rx data", rxData, eRx);
          check(obs == eTx, "R2 8-bit tx MSB first", obs, eTx);
        end else begin
          check(rxData == eRx, "R3 4-bit rx with upper kept", rxData, eRx);
          check(obs[3:0] == eTx[3:0], "R3 4-bit tx nibble", {4'd0, obs[3:0]},
                {4'd0, eTx[3:0]});
        end
        check(done && !busy, "R6 done set busy clear", {6'd0, done, busy}, 8'h02);
        if (sckOe) check(gapOk, "R5 half period", {7'd0, gapOk}, 8'h01);
      end
      irqPrev = irq;
    end
  end

  task automatic xfer(input logic len8, input logic ext, input logic off,
                      input logic [7:0] tx, input logic [7:0] rx,
                      input logic intrude);
    int n;
    n = len8 ? 8 : 4;
    @(negedge clk);
    cfgWr = 1; cfgLen8 = len8; cfgExtClk = ext; cfgOutOff = off;
    @(negedge clk);
    cfgWr = 0; dataWr = 1; txData = tx;
    @(negedge clk);
    dataWr = 0;
    check(sdOe == !off, "R9 data output enable", {7'd0, sdOe}, {7'd0, !off});
    check(sckOe == !ext, "R8 clock output enable", {7'd0, sckOe}, {7'd0, !ext});
    if (len8) begin
      expRx.push_back(rx);
      slvRx = rx;
      slvIdx = 7;
    end else begin
      expRx.push_back({tx[7:4], rx[3:0]});
      slvRx = {rx[3:0], 4'h0};
      slvIdx = 7;
    end
    expTx.push_back(len8 ? tx : {4'h0, tx[3:0]});
    expLen8.push_back(len8);
    obs = 0; gapOk = 1; sawToggle = 0; toggleGap = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    check(busy && !done, "R6 R7 start clears done sets busy", {6'd0, busy, done}, 8'h02);
    if (intrude) begin
      repeat (10) @(negedge clk);
      dataWr = 1; txData = ~tx; cfgWr = 1; cfgExtClk = 1; cfgLen8 = !len8;
      start = 1;
      @(negedge clk);
      dataWr = 0; cfgWr = 0; start = 0;
      @(negedge clk);
      check(sckOe == 1'b1 && busy, "R7 config write ignored while busy",
            {6'd0, sckOe, busy}, 8'h03);
    end
    if (ext) begin
      for (int i = 0; i < n; i++) begin
        sckIn = 0;
        sdIn = slvRx[7 - i];
        repeat (8) @(negedge clk);
        obs = {obs[6:0], sdOut};
        sckIn = 1;
        repeat (8) @(negedge clk);
      end
      check(sckOut == 1'b1, "R8 internal clock idle in external mode",
            {7'd0, sckOut}, 8'h01);
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", wd);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !irq, "R1 reset flags", {5'd0, busy, done, irq}, 8'h00);
    check(rxData == 8'h00, "R1 reset rxData", rxData, 8'h00);
    check(sckOut && sdOut && sckOe && sdOe, "R1 reset pins",
          {4'd0, sckOut, sdOut, sckOe, sdOe}, 8'h0f);
    rstN = 1;
    repeat (2) @(negedge clk);
    xfer(1, 0, 0, 8'hA5, 8'h3C, 0);  // R2 internal 8-bit
    xfer(1, 0, 0, 8'h01, 8'hFE, 0);  // R2 edge patterns
    xfer(0, 0, 0, 8'h9B, 8'h06, 0);  // R3 internal nibble
    xfer(1, 0, 1, 8'h5A, 8'hC3, 0);  // R9 output disabled
    xfer(1, 0, 0, 8'h96, 8'h71, 1);  // R7 writes while busy
    xfer(1, 1, 0, 8'hE4, 8'h2D, 0);  // R8 external 8-bit
    xfer(0, 1, 0, 8'h7C, 8'h0A, 0);  // R8 R3 external nibble
    check(expRx.size() == 0, "R6 every transfer completed",
          8'(expRx.size()), 8'h00);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule